// File: doc/BRIEF.md
# Bit-Serial Distributed Arithmetic FIR Filter

This block is a finite impulse response filter that uses no multipliers. Each accepted input sample enters a parallel delay line. A copy of every tap word is then streamed out one bit per clock, least significant bit first. On every bit clock, the current bit of each tap forms an address into a small constant table. Entry `a` of the table holds the sum of the coefficients whose address bits are set in `a`. A scaling accumulator adds the table outputs, each weighted by its bit position, and halves its running value once per bit. After the last bit it delivers the full-precision convolution result together with a one-cycle valid pulse.

The coefficients are elaboration parameters. When the `SYMMETRIC` parameter is set, taps that share a coefficient are first summed by serial adders, so the table needs only half as many address bits. Each pre-added word is one bit wider than a sample, so one conversion takes one extra bit clock in this mode.

A host presents a sample with a one-cycle load strobe and waits for the valid pulse before it presents the next sample.

Top module: `da_fir`

## Requirements
- R1: While and after reset, `result` is 0 and `resultValid` is 0, and every tap of the delay line holds 0. The first results are therefore computed as if all earlier samples were zero.
- R2: After each accepted sample x[k], `result` equals the sum over i of C_i·x[k-i], computed exactly in two's complement. Its width is COEF_W + ADDR_W + 1 + SER_W bits.
- R3: Coefficient C_i is packed at `COEFS[i*COEF_W +: COEF_W]` as a signed value, and tap i holds x[k-i]. A unit impulse followed by zeros therefore yields C0, C1, C2, and so on, on successive results.
- R4: Samples are signed two's complement. The table output for the sign bit is subtracted rather than added, so the extreme inputs -2^(DATA_W-1) and 2^(DATA_W-1)-1 give exact results, including with a coefficient of -128.
- R5: With `SYMMETRIC`=1, taps i and NUM_TAPS-1-i are summed bit-serially before the table, and the table has ceil(NUM_TAPS/2) address bits. When NUM_TAPS is odd, the middle tap addresses the table on its own. The serial word is DATA_W+1 bits, so SER_W = DATA_W+1. The coefficient set must be symmetric.
- R6: `resultValid` is high for exactly one cycle: the cycle after the SER_W-th rising edge that follows the edge which accepted the load. SER_W = DATA_W when `SYMMETRIC`=0.
- R7: A `sampleLoad` that arrives while a conversion is in progress is ignored. That sample never enters the delay line and does not disturb the result in progress.
- R8: `result` keeps its value from one valid pulse until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleLoad | input | 1 | Strobe to accept `sampleIn` when the filter is idle |
| sampleIn | input | DATA_W | Signed input sample |
| result | output | COEF_W+ADDR_W+1+SER_W | Signed filter output |
| resultValid | output | 1 | One-cycle pulse marking a new `result` |

## Verification
The checker's latency and spacing counters assume that `sampleLoad` is synchronous to `clk` and that reset starts low. They also assume that a load counts as accepted only when the controller is idle, so a strobe during a conversion must leave the pulse timing untouched. The stimulus drives every input on the falling edge and waits out the whole conversion window before the next legal load. It raises `sampleLoad` during a conversion only inside that window, well before the valid pulse. Every coefficient set in the bench is symmetric wherever symmetric mode is enabled.

// File: rtl/da_fir_pkg.sv
`timescale 1ns/1ps
package da_fir_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // accept a sample, clear accumulator and pre-add carries
    logic step;   // consume one serial bit on every tap
    logic last;   // the bit being consumed carries negative weight
  } daStrobe_t;

  typedef enum logic {
    ST_IDLE,
    ST_SHIFT
  } daState_t;

endpackage

// File: rtl/da_fir_ctrl.sv
`timescale 1ns/1ps
module da_fir_ctrl
  import da_fir_pkg::*;
#(
  parameter int SER_W = 9,
  localparam int CNT_W = $clog2(SER_W + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleLoad,
  output daStrobe_t stb,
  output logic      running
);

  daState_t         state;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sampleLoad) begin
            state  <= ST_SHIFT;
            bitCnt <= '0;
          end
        end
        ST_SHIFT: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == CNT_W'(SER_W - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign running = (state == ST_SHIFT);

  always_comb begin
    stb.load = sampleLoad && !running;
    stb.step = running;
    stb.last = running && (bitCnt == CNT_W'(SER_W - 1));
  end

endmodule

// File: rtl/da_fir_table.sv
`timescale 1ns/1ps
module da_fir_table #(
  parameter int ADDR_W = 3,
  parameter int COEF_W = 8,
  parameter logic [ADDR_W*COEF_W-1:0] TBL_COEFS = '0,
  localparam int TBL_W = COEF_W + ADDR_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0]       addr,
  output logic signed [TBL_W-1:0] entry
);

  // Sum of the coefficients whose address bit is set
  function automatic logic signed [TBL_W-1:0] partialSum(input int a);
    logic signed [TBL_W-1:0] s;
    s = '0;
    for (int j = 0; j < ADDR_W; j++) begin
      if (a[j]) s = s + TBL_W'($signed(TBL_COEFS[j*COEF_W +: COEF_W]));
    end
    return s;
  endfunction

  logic signed [TBL_W-1:0] sums [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    assign sums[e] = partialSum(e);
  end

  assign entry = sums[addr];

endmodule

// File: rtl/da_fir_datapath.sv
`timescale 1ns/1ps
module da_fir_datapath
  import da_fir_pkg::*;
#(
  parameter int NUM_TAPS = 6,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter bit SYMMETRIC = 1'b1,
  parameter int SER_W = 9,
  parameter int ADDR_W = 3,
  parameter int RES_W = 21,
  parameter logic [ADDR_W*COEF_W-1:0] TBL_COEFS = '0,
  localparam int TBL_W = COEF_W + ADDR_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  daStrobe_t                stb,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [RES_W-1:0]  result,
  output logic                     resultValid
);

  logic signed [DATA_W-1:0] tapWord  [NUM_TAPS];
  logic signed [DATA_W-1:0] feedWord [NUM_TAPS];
  logic [SER_W-1:0]         tapSer   [NUM_TAPS];
  logic [ADDR_W-1:0]        tblAddr;
  logic signed [TBL_W-1:0]  tblOut;
  logic signed [TBL_W:0]    tblExt;
  logic signed [TBL_W:0]    accHi;
  logic signed [TBL_W:0]    accSum;
  logic [SER_W-1:0]         accLo;

  // Delay line of whole words, plus a serial copy of each tap
  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    if (t == 0) begin : g_head
      assign feedWord[t] = sampleIn;
    end else begin : g_body
      assign feedWord[t] = tapWord[t-1];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tapWord[t] <= '0;
        tapSer[t]  <= '0;
      end else if (stb.load) begin
        tapWord[t] <= feedWord[t];
        tapSer[t]  <= SER_W'(feedWord[t]);
      end else if (stb.step) begin
        tapSer[t]  <= {tapSer[t][SER_W-1], tapSer[t][SER_W-1:1]};
      end
    end
  end

  // Table address: raw tap bits, or serial pre-added pairs
  if (SYMMETRIC) begin : g_sym
    for (genvar p = 0; p < NUM_TAPS / 2; p++) begin : g_pair
      logic aBit, bBit, carry;
      assign aBit = tapSer[p][0];
      assign bBit = tapSer[NUM_TAPS-1-p][0];
      assign tblAddr[p] = aBit ^ bBit ^ carry;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         carry <= 1'b0;
        else if (stb.load) carry <= 1'b0;
        else if (stb.step) carry <= (aBit & bBit) | (aBit & carry) | (bBit & carry);
      end
    end
    if (NUM_TAPS % 2 == 1) begin : g_mid
      assign tblAddr[NUM_TAPS/2] = tapSer[NUM_TAPS/2][0];
    end
  end else begin : g_plain
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_bit
      assign tblAddr[t] = tapSer[t][0];
    end
  end

  da_fir_table #(
    .ADDR_W   (ADDR_W),
    .COEF_W   (COEF_W),
    .TBL_COEFS(TBL_COEFS)
  ) u_table (
    .addr (tblAddr),
    .entry(tblOut)
  );

  // Scaling accumulator: add or subtract, then halve; shifted-out bits kept
  assign tblExt = {tblOut[TBL_W-1], tblOut};
  assign accSum = stb.last ? (accHi - tblExt) : (accHi + tblExt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accHi       <= '0;
      accLo       <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= stb.last;
      if (stb.load) begin
        accHi <= '0;
        accLo <= '0;
      end else if (stb.step) begin
        accHi <= accSum >>> 1;
        accLo <= {accSum[0], accLo[SER_W-1:1]};
      end
      if (stb.last) begin
        result <= {accSum[TBL_W], accSum[TBL_W:1], accSum[0], accLo[SER_W-1:1]};
      end
    end
  end

endmodule

// File: rtl/da_fir.sv
`timescale 1ns/1ps
module da_fir
  import da_fir_pkg::*;
#(
  parameter int NUM_TAPS = 6,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter bit SYMMETRIC = 1'b1,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS =
    {8'h03, 8'hFB, 8'h0C, 8'h0C, 8'hFB, 8'h03},
  localparam int SER_W = DATA_W + (SYMMETRIC ? 1 : 0),
  localparam int ADDR_W = SYMMETRIC ? (NUM_TAPS + 1) / 2 : NUM_TAPS,
  localparam int RES_W = COEF_W + ADDR_W + 1 + SER_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleLoad,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [RES_W-1:0]  result,
  output logic                     resultValid
);

  daStrobe_t stb;
  logic      running;

  da_fir_ctrl #(
    .SER_W(SER_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleLoad(sampleLoad),
    .stb       (stb),
    .running   (running)
  );

  da_fir_datapath #(
    .NUM_TAPS (NUM_TAPS),
    .DATA_W   (DATA_W),
    .COEF_W   (COEF_W),
    .SYMMETRIC(SYMMETRIC),
    .SER_W    (SER_W),
    .ADDR_W   (ADDR_W),
    .RES_W    (RES_W),
    .TBL_COEFS(COEFS[ADDR_W*COEF_W-1:0])
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .sampleIn   (sampleIn),
    .result     (result),
    .resultValid(resultValid)
  );

endmodule

// File: rtl/da_fir_checker.sv
`timescale 1ns/1ps
module da_fir_checker #(
  parameter int SER_W = 9,
  parameter int RES_W = 21,
  localparam int PH_W = $clog2(SER_W + 2)
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleLoad,
  input logic             running,
  input logic             resultValid,
  input logic [RES_W-1:0] result
);

  logic [PH_W-1:0] phase;   // cycles since the accepted load
  logic [PH_W-1:0] gap;     // cycles since the last valid, saturating

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      gap   <= PH_W'(SER_W);
    end else begin
      if (sampleLoad && !running) phase <= PH_W'(1);
      else if (resultValid)       phase <= '0;
      else if (phase != '0)       phase <= phase + 1'b1;

      if (resultValid)                gap <= '0;
      else if (gap != PH_W'(SER_W))   gap <= gap + 1'b1;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> phase == PH_W'(SER_W + 1));                        // R6

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);                                     // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(result));                                 // R8

  AST_BUSY_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> gap == PH_W'(SER_W));                              // R7

endmodule

bind da_fir da_fir_checker #(
  .SER_W(SER_W),
  .RES_W(RES_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleLoad (sampleLoad),
  .running    (running),
  .resultValid(resultValid),
  .result     (result)
);

// File: tb/tb_da_fir.sv
`timescale 1ns/1ps
module tb_da_fir;

  localparam int DW = 8;
  localparam int CW = 8;
  localparam int RW_MAIN  = CW + 3 + 1 + DW + 1;
  localparam int RW_PLAIN = CW + 4 + 1 + DW;
  localparam int RW_ODD   = CW + 3 + 1 + DW + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleLoad = 1'b0;
  logic signed [DW-1:0] sampleIn = '0;

  logic signed [RW_MAIN-1:0]  resMain;
  logic signed [RW_PLAIN-1:0] resPlain;
  logic signed [RW_ODD-1:0]   resOdd;
  logic vMain, vPlain, vOdd;

  always #2 clk = ~clk;   // 250 MHz

  da_fir #(
    .NUM_TAPS(6), .DATA_W(DW), .COEF_W(CW), .SYMMETRIC(1'b1),
    .COEFS({8'h03, 8'hFB, 8'h0C, 8'h0C, 8'hFB, 8'h03})
  ) dut (
    .clk(clk), .rstN(rstN), .sampleLoad(sampleLoad), .sampleIn(sampleIn),
    .result(resMain), .resultValid(vMain)
  );

  da_fir #(
    .NUM_TAPS(4), .DATA_W(DW), .COEF_W(CW), .SYMMETRIC(1'b0),
    .COEFS({8'h01, 8'h80, 8'hFD, 8'h07})
  ) dutPlain (
    .clk(clk), .rstN(rstN), .sampleLoad(sampleLoad), .sampleIn(sampleIn),
    .result(resPlain), .resultValid(vPlain)
  );

  da_fir #(
    .NUM_TAPS(5), .DATA_W(DW), .COEF_W(CW), .SYMMETRIC(1'b1),
    .COEFS({8'h02, 8'hF9, 8'h09, 8'hF9, 8'h02})
  ) dutOdd (
    .clk(clk), .rstN(rstN), .sampleLoad(sampleLoad), .sampleIn(sampleIn),
    .result(resOdd), .resultValid(vOdd)
  );

  int cMain[6]  = '{3, -5, 12, 12, -5, 3};
  int cPlain[4] = '{7, -3, -128, 1};
  int cOdd[5]   = '{2, -7, 9, -7, 2};
  int hist[6]   = '{0, 0, 0, 0, 0, 0};
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input string who, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, who, got, exp);
    end
  endtask

  // Push one sample, optionally strobe a stray load mid-conversion
  task automatic runSample(input int v, input bit junk, input string tag);
    int eM, eP, eO, nM, nP, nO, aM, aP, aO, rM, rP, rO;
    eM = 0; eP = 0; eO = 0; nM = 0; nP = 0; nO = 0;
    aM = 0; aP = 0; aO = 0; rM = 0; rP = 0; rO = 0;
    @(negedge clk);
    sampleLoad = 1'b1;
    sampleIn   = DW'(v);
    @(negedge clk);
    sampleLoad = 1'b0;
    for (int t = 5; t > 0; t--) hist[t] = hist[t-1];
    hist[0] = v;
    for (int t = 0; t < 6; t++) eM += cMain[t] * hist[t];
    for (int t = 0; t < 4; t++) eP += cPlain[t] * hist[t];
    for (int t = 0; t < 5; t++) eO += cOdd[t] * hist[t];
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (vMain)  begin nM++; aM = i; rM = int'(resMain);  end
      if (vPlain) begin nP++; aP = i; rP = int'(resPlain); end
      if (vOdd)   begin nO++; aO = i; rO = int'(resOdd);   end
      if (junk && i == 2) begin sampleLoad = 1'b1; sampleIn = DW'(90); end
      if (junk && i == 3) sampleLoad = 1'b0;
    end
    check(tag, "main value", rM, eM);
    check(tag, "plain value", rP, eP);
    check(tag, "odd value", rO, eO);
    check("R5", "main latency", aM, DW + 1);
    check("R5", "odd latency", aO, DW + 1);
    check("R6", "plain latency", aP, DW);
    check("R6", "pulse count", nM + 100 * nP + 10000 * nO, 10101);
    check("R8", "main hold", int'(resMain), eM);
    check("R8", "plain hold", int'(resPlain), eP);
    check("R8", "odd hold", int'(resOdd), eO);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1", "main reset value", int'(resMain), 0);
    check("R1", "plain reset value", int'(resPlain), 0);
    check("R1", "odd reset value", int'(resOdd), 0);
    check("R1", "reset valid", int'({vMain, vPlain, vOdd}), 0);
    rstN = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check("R1", "idle valid", int'({vMain, vPlain, vOdd}), 0);
    end

    // Impulse: each coefficient appears in tap order
    runSample(1, 1'b0, "R3");
    for (int k = 0; k < 6; k++) runSample(0, 1'b0, "R3");
    runSample(-1, 1'b0, "R4");
    for (int k = 0; k < 6; k++) runSample(0, 1'b0, "R4");

    // Every sample value, in scrambled order, with stray loads sprinkled in
    for (int k = 0; k < 256; k++) begin
      int v;
      bit j;
      v = ((k * 37 + 11) % 256) - 128;
      j = (k % 16 == 5);
      runSample(v, j, j ? "R7" : "R2");
    end

    // Extremes
    for (int k = 0; k < 6; k++) runSample(-128, 1'b0, "R4");
    for (int k = 0; k < 6; k++) runSample(127, 1'b0, "R4");
    for (int k = 0; k < 8; k++) runSample((k % 2 == 0) ? -128 : 127, k == 3, "R4");
    runSample(55, 1'b0, "R7");

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R6 watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule